// File: doc/BRIEF.md
# Bidirectional GPIO Port with Output Latch

This block is one eight-bit general-purpose I/O port behind a small register bus. Software loads an output latch either one byte at a time or one bit at a time. A per-nibble mode register decides how each group of four pins is driven. In push-pull mode the pin is actively driven to the latch value. In open-drain mode only a low level is driven, and a latch one releases the pin by deasserting its output enable.

Reads of the data register normally return the pin levels after a two-flop synchronizer. A read marked as the first phase of a read-modify-write returns the latch instead. A bit or byte update sequence therefore starts from the value software last wrote, not from whatever an external load pulls the pin to. The latch stays fully usable when the pins are not connected to anything.

Read data is registered, so `rd_valid` marks the result one cycle after the request. Reset is asynchronous and active low, and its release is synchronized inside the block.

Top module: `gpio_port`

## Requirements
- R1: After reset the latch is zero and every nibble is in open-drain mode. `pin_out` is therefore all zeros, `pin_oe` is all ones, and reading address 1 returns 0.
- R2: A byte write (`bus_wr`=1, `bus_bitw`=0) to address 0 loads `bus_wdata` into the latch.
- R3: A bit write (`bus_wr`=1, `bus_bitw`=1) to address 0 sets latch bit `bus_bitsel` to `bus_wdata[0]` and leaves the other seven bits unchanged.
- R4: A read of address 0 with `bus_rmw`=0 returns the synchronized pin levels, whatever the latch holds.
- R5: A read of address 0 with `bus_rmw`=1 returns the latch contents, whatever the pins show.
- R6: Pin inputs pass through two flops. A pin change made before rising edge E1 is returned by a plain read sampled at edge E3. A read sampled at E1 or E2 still returns the old level.
- R7: When mode bit k is 1 (push-pull), pins 4k+3..4k have `pin_oe`=1 and `pin_out` equal to the latch bits.
- R8: When mode bit k is 0 (open-drain), pins 4k+3..4k have `pin_out`=0 and `pin_oe` equal to the inverted latch bits.
- R9: Address 1 is the mode register, with bit 0 for pins 3..0 and bit 1 for pins 7..4. A byte write stores `bus_wdata[1:0]`. Writing 0xFF puts every nibble in push-pull mode. A read returns the mode in bits 1..0 with zeros above, for either value of `bus_rmw`.
- R10: `rd_valid` is high exactly one cycle after each cycle with `bus_rd`=1, and `rd_data` is loaded in that same cycle. A read issued in the same cycle as a write returns the value held before the write.
- R11: A bit write to address 1 leaves the mode unchanged. Writes to addresses 2 and 3 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data latch, 1 mode |
| bus_wr | input | 1 | Write strobe |
| bus_bitw | input | 1 | Write targets a single bit |
| bus_bitsel | input | 3 | Bit index for a bit write |
| bus_wdata | input | 8 | Write data; bit 0 carries the value in a bit write |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Read is the first phase of a read-modify-write |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| pin_in | input | 8 | Sampled pin levels, asynchronous |
| pin_out | output | 8 | Value driven onto each pin |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
The assertions assume the bus inputs are stable around each rising edge. They also assume `bus_bitsel` always names an existing bit. Pin-read properties compare against the synchronizer output, so they make no assumption about when `pin_in` changes.

The bench changes all inputs only on falling edges and always drives an in-range bit index. Before any plain read that is checked against a pin value, it holds `pin_in` steady for at least three cycles. The exception is the sequence that probes the synchronizer latency, which changes the pins deliberately between reads.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    RSEL_DATA = 2'd0,
    RSEL_MODE = 2'd1,
    RSEL_RSV2 = 2'd2,
    RSEL_RSV3 = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     wr;
    logic     bitw;
    logic     rd;
    logic     rmw;
    reg_sel_e sel;
  } bus_req_t;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_in;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NIBS   = 2,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_req_t          req,
  input  logic [SEL_W-1:0]  bitsel,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] latch_q,
  output logic [NIBS-1:0]   mode_q
);

  logic [PORT_W-1:0] latch_d;
  logic [PORT_W-1:0] bit_mask;
  logic [NIBS-1:0]   mode_d;
  logic              latch_en;
  logic              mode_en;

  always_comb begin
    bit_mask         = '0;
    bit_mask[bitsel] = 1'b1;
    latch_en = req.wr && (req.sel == RSEL_DATA);
    mode_en  = req.wr && !req.bitw && (req.sel == RSEL_MODE);
    if (req.bitw) begin
      latch_d = (latch_q & ~bit_mask) | (bit_mask & {PORT_W{wdata[0]}});
    end else begin
      latch_d = wdata;
    end
    mode_d = wdata[NIBS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      mode_q  <= '0;
    end else begin
      if (latch_en) begin
        latch_q <= latch_d;
      end
      if (mode_en) begin
        mode_q <= mode_d;
      end
    end
  end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int PORT_W = 8,
  parameter int NIB_W  = 4,
  parameter int NIBS   = 2
) (
  input  logic [PORT_W-1:0] latch_q,
  input  logic [NIBS-1:0]   mode_q,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe
);

  for (genvar k = 0; k < NIBS; k++) begin : g_nib
    logic [NIB_W-1:0] nib_latch;
    assign nib_latch = latch_q[k*NIB_W +: NIB_W];

    always_comb begin
      if (mode_q[k]) begin
        pin_out[k*NIB_W +: NIB_W] = nib_latch;
        pin_oe[k*NIB_W +: NIB_W]  = '1;
      end else begin
        pin_out[k*NIB_W +: NIB_W] = '0;
        pin_oe[k*NIB_W +: NIB_W]  = ~nib_latch;
      end
    end
  end

endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
  import gpio_port_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NIBS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_req_t          req,
  input  logic [PORT_W-1:0] latch_q,
  input  logic [NIBS-1:0]   mode_q,
  input  logic [PORT_W-1:0] pin_sync,
  output logic [PORT_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [PORT_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    unique case (req.sel)
      RSEL_DATA: rd_next = req.rmw ? latch_q : pin_sync;
      RSEL_MODE: rd_next[NIBS-1:0] = mode_q;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= req.rd;
      if (req.rd) begin
        rd_data <= rd_next;
      end
    end
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int NIB_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(PORT_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_bitw,
  input  logic [SEL_W-1:0]      bus_bitsel,
  input  logic [PORT_W-1:0]     bus_wdata,
  input  logic                  bus_rd,
  input  logic                  bus_rmw,
  output logic [PORT_W-1:0]     rd_data,
  output logic                  rd_valid,
  input  logic [PORT_W-1:0]     pin_in,
  output logic [PORT_W-1:0]     pin_out,
  output logic [PORT_W-1:0]     pin_oe
);

  localparam int NIBS = PORT_W / NIB_W;

  logic              rst_core_n;
  bus_req_t          req;
  logic [PORT_W-1:0] latch_q;
  logic [NIBS-1:0]   mode_q;
  logic [PORT_W-1:0] pin_sync;

  always_comb begin
    req.wr   = bus_wr;
    req.bitw = bus_bitw;
    req.rd   = bus_rd;
    req.rmw  = bus_rmw;
    req.sel  = reg_sel_e'(bus_addr);
  end

  gpio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  gpio_in_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_port_regs #(.PORT_W(PORT_W), .NIBS(NIBS), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .req     (req),
    .bitsel  (bus_bitsel),
    .wdata   (bus_wdata),
    .latch_q (latch_q),
    .mode_q  (mode_q)
  );

  gpio_pad_drive #(.PORT_W(PORT_W), .NIB_W(NIB_W), .NIBS(NIBS)) u_pad (
    .latch_q (latch_q),
    .mode_q  (mode_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  gpio_rd_path #(.PORT_W(PORT_W), .NIBS(NIBS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .req      (req),
    .latch_q  (latch_q),
    .mode_q   (mode_q),
    .pin_sync (pin_sync),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int PORT_W = 8,
  parameter int NIB_W  = 4,
  parameter int NIBS   = 2,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic [1:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_bitw,
  input logic [SEL_W-1:0]  bus_bitsel,
  input logic [PORT_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic              bus_rmw,
  input logic [PORT_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic [PORT_W-1:0] latch_q,
  input logic [NIBS-1:0]   mode_q,
  input logic [PORT_W-1:0] pin_sync
);

  logic [PORT_W-1:0] sel_mask;
  always_comb begin
    sel_mask             = '0;
    sel_mask[bus_bitsel] = 1'b1;
  end

  a_r2_byte_load: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wr && !bus_bitw && bus_addr == 2'd0) |=> latch_q == $past(bus_wdata));

  a_r3_bit_value: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wr && bus_bitw && bus_addr == 2'd0) |=> latch_q[$past(bus_bitsel)] == $past(bus_wdata[0]));

  a_r3_bit_others: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wr && bus_bitw && bus_addr == 2'd0) |=> ((latch_q ^ $past(latch_q)) & ~$past(sel_mask)) == '0);

  a_r4_pin_read: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_rd && !bus_rmw && bus_addr == 2'd0) |=> rd_data == $past(pin_sync));

  a_r5_rmw_latch: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_rd && bus_rmw && bus_addr == 2'd0) |=> rd_data == $past(latch_q));

  a_r10_valid_set: assert property (@(posedge clk) disable iff (!rst_core_n)
    bus_rd |=> rd_valid);

  a_r10_valid_clr: assert property (@(posedge clk) disable iff (!rst_core_n)
    !bus_rd |=> !rd_valid);

  a_r11_mode_bitw: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wr && bus_bitw && bus_addr == 2'd1) |=> $stable(mode_q));

  for (genvar k = 0; k < NIBS; k++) begin : g_nib_chk
    a_r7_push_pull: assert property (@(posedge clk) disable iff (!rst_core_n)
      mode_q[k] |-> (pin_oe[k*NIB_W +: NIB_W] == '1 &&
                     pin_out[k*NIB_W +: NIB_W] == latch_q[k*NIB_W +: NIB_W]));

    a_r8_open_drain: assert property (@(posedge clk) disable iff (!rst_core_n)
      !mode_q[k] |-> (pin_out[k*NIB_W +: NIB_W] == '0 &&
                      pin_oe[k*NIB_W +: NIB_W] == ~latch_q[k*NIB_W +: NIB_W]));
  end

endmodule

bind gpio_port gpio_port_chk #(
  .PORT_W (PORT_W),
  .NIB_W  (NIB_W),
  .NIBS   (NIBS),
  .SEL_W  (SEL_W)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_bitw   (bus_bitw),
  .bus_bitsel (bus_bitsel),
  .bus_wdata  (bus_wdata),
  .bus_rd     (bus_rd),
  .bus_rmw    (bus_rmw),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .latch_q    (latch_q),
  .mode_q     (mode_q),
  .pin_sync   (pin_sync)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

  logic       clk;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic       bus_bitw;
  logic [2:0] bus_bitsel;
  logic [7:0] bus_wdata;
  logic       bus_rd;
  logic       bus_rmw;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic [7:0] pin_in;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] m_latch;
  logic [1:0] m_mode;
  logic [7:0] m_pin;

  gpio_port u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_bitw   (bus_bitw),
    .bus_bitsel (bus_bitsel),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rmw    (bus_rmw),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per valid read result.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R10: unexpected rd_valid, actual %h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  function automatic logic [7:0] model_read(input logic [1:0] a, input logic rmw);
    case (a)
      2'd0:    return rmw ? m_latch : m_pin;
      2'd1:    return {6'b0, m_mode};
      default: return 8'h00;
    endcase
  endfunction

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0; bus_bitw = 1'b0; bus_rd = 1'b0; bus_rmw = 1'b0;
    bus_addr = 2'd0; bus_bitsel = 3'd0; bus_wdata = 8'h00;
  endtask

  task automatic wr_byte(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_bitw = 1'b0; bus_wdata = d;
    bus_rd = 1'b0; bus_rmw = 1'b0; bus_bitsel = 3'd0;
    if (a == 2'd0) m_latch = d;
    if (a == 2'd1) m_mode = d[1:0];
  endtask

  task automatic wr_bit(input logic [1:0] a, input logic [2:0] sel, input logic v);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_bitw = 1'b1; bus_bitsel = sel;
    bus_wdata = {7'b0, v}; bus_rd = 1'b0; bus_rmw = 1'b0;
    if (a == 2'd0) m_latch[sel] = v;
  endtask

  task automatic rd_val(input logic [1:0] a, input logic rmw, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_rmw = rmw; bus_wr = 1'b0; bus_bitw = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic rd(input logic [1:0] a, input logic rmw, input string tag);
    rd_val(a, rmw, model_read(a, rmw), tag);
  endtask

  task automatic check_pins(input string tag);
    logic [7:0] eo, ee;
    idle();
    for (int k = 0; k < 2; k++) begin
      if (m_mode[k]) begin
        eo[k*4 +: 4] = m_latch[k*4 +: 4];
        ee[k*4 +: 4] = 4'hF;
      end else begin
        eo[k*4 +: 4] = 4'h0;
        ee[k*4 +: 4] = ~m_latch[k*4 +: 4];
      end
    end
    check({tag, " pin_out"}, pin_out, eo);
    check({tag, " pin_oe"}, pin_oe, ee);
  endtask

  task automatic set_pins(input logic [7:0] p);
    pin_in = p;
    m_pin  = p;
    repeat (3) idle();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_addr = 2'd0; bus_wr = 1'b0; bus_bitw = 1'b0; bus_bitsel = 3'd0;
    bus_wdata = 8'h00; bus_rd = 1'b0; bus_rmw = 1'b0; pin_in = 8'h00;
    m_latch = 8'h00; m_mode = 2'b00; m_pin = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle();

    // R1: reset state
    check_pins("R1");
    check("R1 rd_valid idle", {7'b0, rd_valid}, 8'h00);
    rd(2'd1, 1'b0, "R1 mode");
    rd(2'd0, 1'b1, "R1 latch");
    idle();

    // R4 / R5: pin read versus latch read
    set_pins(8'hA5);
    rd(2'd0, 1'b0, "R4 pin read");
    rd(2'd0, 1'b1, "R5 latch read");

    // R2 / R8: byte load, open-drain drive
    wr_byte(2'd0, 8'h3C);
    check_pins("R8");
    rd(2'd0, 1'b1, "R2 latch");
    rd(2'd0, 1'b0, "R4 pin not latch");

    // R7 / R9: low nibble push-pull
    wr_byte(2'd1, 8'h01);
    check_pins("R7");
    rd(2'd1, 1'b0, "R9 mode low");

    // R3: bit writes
    wr_bit(2'd0, 3'd7, 1'b1);
    wr_bit(2'd0, 3'd2, 1'b0);
    wr_bit(2'd0, 3'd0, 1'b1);
    rd_val(2'd0, 1'b1, 8'hB9, "R3 bit writes");
    check_pins("R3");

    // R11: ignored writes
    wr_bit(2'd1, 3'd0, 1'b0);
    rd_val(2'd1, 1'b1, 8'h01, "R11 mode bitw");
    wr_byte(2'd2, 8'hFF);
    wr_byte(2'd3, 8'hFF);
    rd(2'd2, 1'b0, "R11 rsv2");
    rd(2'd3, 1'b1, "R11 rsv3");
    rd(2'd0, 1'b1, "R11 latch kept");
    check_pins("R11");

    // R9 / R7: all ones selects push-pull everywhere
    wr_byte(2'd1, 8'hFF);
    rd_val(2'd1, 1'b1, 8'h03, "R9 mode all");
    check_pins("R7 all");

    // R10: read in same cycle as write sees prior value
    @(negedge clk);
    bus_addr = 2'd0; bus_wr = 1'b1; bus_bitw = 1'b0; bus_wdata = 8'h55;
    bus_rd = 1'b1; bus_rmw = 1'b1;
    exp_q.push_back(8'hB9); tag_q.push_back("R10 same-cycle");
    m_latch = 8'h55;
    rd(2'd0, 1'b1, "R10 after write");

    // R6: synchronizer latency, back-to-back plain reads
    rd_val(2'd0, 1'b0, 8'hA5, "R6 edge1 old");
    pin_in = 8'h5A;
    rd_val(2'd0, 1'b0, 8'hA5, "R6 edge2 old");
    rd_val(2'd0, 1'b0, 8'h5A, "R6 edge3 new");
    m_pin = 8'h5A;
    idle();

    // R5: latch stays independent of pins
    set_pins(8'h00);
    rd(2'd0, 1'b1, "R5 latch vs pins");
    rd(2'd0, 1'b0, "R4 pins zero");
    wr_byte(2'd1, 8'h00);
    check_pins("R8 back to open-drain");

    repeat (4) idle();
    if (exp_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R10: actual %0d results missing expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule